// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible register front end of a colour LCD controller. It sits on a simple 32-bit bus with a 4 KB window addressed in bytes, where only whole-word accesses are decoded. It stores four display timing words, two frame base addresses, a control word, an interrupt enable mask and a raw interrupt status vector. From those writes it derives the values that the pixel pipeline consumes: the active pixel columns, the active lines, a pixel-depth code and a single enable.

A static strap selects one of three register layouts. In the base layout the interrupt mask lives at word 6 and control at word 7. In both derived layouts those two words trade places, for reads and for writes. The top eight words of the window return fixed identification bytes, and one of the derived layouts carries its own identification bytes. Interrupt events from the rest of the controller enter as one-cycle set pulses into the raw status. A one-cycle pulse after every accepted register write tells downstream logic to refresh whatever it derives from the registers.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset every stored register, the derived column and line counts, the depth code, the enable and the write pulse are zero.
- R2: Words 0 to 3 (byte addresses 0x00, 0x04, 0x08, 0x0C) hold the timing values; words 4 and 5 hold the upper and lower frame base, and words 11 and 12 read back the upper and lower base again. Read data is combinational from the address.
- R3: A write to word 0 sets the column count to ((data AND 0xFC) + 4) * 4, visible from the clock edge that accepts the write; columns change on no other event.
- R4: A write to word 1 sets the line count to (data AND 0x3FF) + 1.
- R5: Enable is high only while control bit 0 and control bit 11 are both set; the depth code equals control bits 3:1.
- R6: With the layout strap at 0, word 6 (0x18) is the interrupt mask and word 7 (0x1C) is control; with strap 1, 2 or 3 the two words are swapped for reads and writes.
- R7: Word 8 (0x20) reads raw status and word 9 (0x24) reads raw status AND mask; bits above the status width read zero. Status bit i is set by a high on irq_set_i[i].
- R8: A write to word 10 (0x28) clears every raw status bit that is one in the written data; when a set and a clear hit the same bit in one cycle, the bit ends set.
- R9: Byte addresses 0xFE0 to 0xFFC return one identification byte per word in bits 7:0. Straps 0 and 1 give 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order; straps 2 and 3 give 0x11, 0x11, 0x24, 0x00 and then the same last four bytes.
- R10: Reads of unmapped words return zero; writes to unmapped or read-only words change no register and raise no write pulse.
- R11: wr_pulse_o is high for exactly the one cycle after each clock edge that accepts a write to a writable word (0 to 7 and 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout_i | input | 2 | Register layout strap: 0 base, 1 board, 2/3 extended |
| bus_sel_i | input | 1 | Bus access valid this cycle |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address |
| irq_set_i | input | IRQ_W | Interrupt event pulses into raw status |
| cols_o | output | COL_W | Active pixel columns |
| rows_o | output | ROW_W | Active lines |
| depth_o | output | 3 | Pixel-depth code |
| enabled_o | output | 1 | Controller enable (enable and power both set) |
| wr_pulse_o | output | 1 | One-cycle marker after an accepted write |

## Verification
The bench targets the swap of words 6 and 7: a design that ignored the strap would route a control write into the mask, leaving enable low and corrupting masked status. It drives timing values with bits outside the decoded fields set, so a design that failed to mask them would report a wrong column or line count, and it drives the widest values so an undersized counter would wrap to zero. It raises and clears the same status bit in one cycle, where a clear-wins design would lose an event, and it writes to read-only and unmapped words, where a loose decoder would raise a write pulse or overwrite a neighbour.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    typedef enum logic [3:0] {
        SEL_TIM0    = 4'd0,
        SEL_TIM1    = 4'd1,
        SEL_TIM2    = 4'd2,
        SEL_TIM3    = 4'd3,
        SEL_UBASE   = 4'd4,
        SEL_LBASE   = 4'd5,
        SEL_MASK    = 4'd6,
        SEL_CTRL    = 4'd7,
        SEL_RAW     = 4'd8,
        SEL_MSTAT   = 4'd9,
        SEL_CLEAR   = 4'd10,
        SEL_UCUR    = 4'd11,
        SEL_LCUR    = 4'd12,
        SEL_IDENT   = 4'd13,
        SEL_NONE    = 4'd14
    } reg_sel_e;

    typedef enum logic [1:0] {
        LAYOUT_BASE  = 2'd0,
        LAYOUT_BOARD = 2'd1,
        LAYOUT_EXT   = 2'd2,
        LAYOUT_EXT2  = 2'd3
    } layout_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PWR_BIT = 11;
    localparam int ID_WORDS     = 8;

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        layout_i,
    output reg_sel_e          sel_o,
    output logic [2:0]        id_idx_o
);
    localparam int WORD_W   = ADDR_W - 2;
    localparam int WORDS    = 1 << WORD_W;
    localparam int ID_FIRST = WORDS - ID_WORDS;

    logic [WORD_W-1:0] word;
    logic              swapped;

    assign word     = addr_i[ADDR_W-1:2];
    assign swapped  = (layout_i != LAYOUT_BASE);
    assign id_idx_o = word[2:0];

    always_comb begin
        sel_o = SEL_NONE;
        if (int'(word) >= ID_FIRST) begin
            sel_o = SEL_IDENT;
        end else begin
            case (int'(word))
                0:  sel_o = SEL_TIM0;
                1:  sel_o = SEL_TIM1;
                2:  sel_o = SEL_TIM2;
                3:  sel_o = SEL_TIM3;
                4:  sel_o = SEL_UBASE;
                5:  sel_o = SEL_LBASE;
                6:  sel_o = swapped ? SEL_CTRL : SEL_MASK;
                7:  sel_o = swapped ? SEL_MASK : SEL_CTRL;
                8:  sel_o = SEL_RAW;
                9:  sel_o = SEL_MSTAT;
                10: sel_o = SEL_CLEAR;
                11: sel_o = SEL_UCUR;
                12: sel_o = SEL_LCUR;
                default: sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_id_rom.sv
module lcdc_id_rom
    import lcdc_pkg::*;
(
    input  logic [1:0] layout_i,
    input  logic [2:0] idx_i,
    output logic [7:0] byte_o
);
    logic ext;
    assign ext = (layout_i == LAYOUT_EXT) || (layout_i == LAYOUT_EXT2);

    always_comb begin
        case (idx_i)
            3'd0: byte_o = ext ? 8'h11 : 8'h10;
            3'd1: byte_o = 8'h11;
            3'd2: byte_o = ext ? 8'h24 : 8'h04;
            3'd3: byte_o = 8'h00;
            3'd4: byte_o = 8'h0D;
            3'd5: byte_o = 8'hF0;
            3'd6: byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
    parameter int DATA_W = 32,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 11
) (
    input  logic [DATA_W-1:0] tim0_i,
    input  logic [DATA_W-1:0] tim1_i,
    output logic [COL_W-1:0]  cols_o,
    output logic [ROW_W-1:0]  rows_o
);
    // ((v & 0xFC) + 4) * 4 == (v[7:2] + 1) << 4
    logic [6:0]  col_units;
    logic [10:0] row_count;

    assign col_units = {1'b0, tim0_i[7:2]} + 7'd1;
    assign row_count = {1'b0, tim1_i[9:0]} + 11'd1;
    assign cols_o    = COL_W'({col_units, 4'b0000});
    assign rows_o    = ROW_W'(row_count);
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 5,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        layout_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [IRQ_W-1:0]  irq_set_i,
    output logic [COL_W-1:0]  cols_o,
    output logic [ROW_W-1:0]  rows_o,
    output logic [2:0]        depth_o,
    output logic              enabled_o,
    output logic              wr_pulse_o
);
    localparam int TIM_N = 4;

    typedef struct packed {
        logic [TIM_N-1:0][DATA_W-1:0] tim;
        logic [DATA_W-1:0]            ubase;
        logic [DATA_W-1:0]            lbase;
        logic [DATA_W-1:0]            ctrl;
        logic [IRQ_W-1:0]             mask;
        logic [IRQ_W-1:0]             raw;
        logic [COL_W-1:0]             cols;
        logic [ROW_W-1:0]             rows;
        logic                         pulse;
    } state_t;

    state_t   st_d, st_q;
    reg_sel_e sel;
    logic [2:0] id_idx;
    logic [7:0] id_byte;
    logic [COL_W-1:0] new_cols;
    logic [ROW_W-1:0] new_rows;
    logic do_wr;

    lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i   (bus_addr_i),
        .layout_i (layout_i),
        .sel_o    (sel),
        .id_idx_o (id_idx)
    );

    lcdc_id_rom u_id (
        .layout_i (layout_i),
        .idx_i    (id_idx),
        .byte_o   (id_byte)
    );

    lcdc_geom #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_geom (
        .tim0_i (bus_wdata_i),
        .tim1_i (bus_wdata_i),
        .cols_o (new_cols),
        .rows_o (new_rows)
    );

    assign do_wr = bus_sel_i && bus_wr_i;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.raw   = st_q.raw;
        if (do_wr) begin
            case (sel)
                SEL_TIM0: begin
                    st_d.tim[0] = bus_wdata_i;
                    st_d.cols   = new_cols;
                    st_d.pulse  = 1'b1;
                end
                SEL_TIM1: begin
                    st_d.tim[1] = bus_wdata_i;
                    st_d.rows   = new_rows;
                    st_d.pulse  = 1'b1;
                end
                SEL_TIM2: begin
                    st_d.tim[2] = bus_wdata_i;
                    st_d.pulse  = 1'b1;
                end
                SEL_TIM3: begin
                    st_d.tim[3] = bus_wdata_i;
                    st_d.pulse  = 1'b1;
                end
                SEL_UBASE: begin
                    st_d.ubase = bus_wdata_i;
                    st_d.pulse = 1'b1;
                end
                SEL_LBASE: begin
                    st_d.lbase = bus_wdata_i;
                    st_d.pulse = 1'b1;
                end
                SEL_MASK: begin
                    st_d.mask  = bus_wdata_i[IRQ_W-1:0];
                    st_d.pulse = 1'b1;
                end
                SEL_CTRL: begin
                    st_d.ctrl  = bus_wdata_i;
                    st_d.pulse = 1'b1;
                end
                SEL_CLEAR: begin
                    st_d.raw   = st_q.raw & ~bus_wdata_i[IRQ_W-1:0];
                    st_d.pulse = 1'b1;
                end
                default: ;
            endcase
        end
        // a new event wins over a clear of the same bit
        st_d.raw = st_d.raw | irq_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            SEL_TIM0:  bus_rdata_o = st_q.tim[0];
            SEL_TIM1:  bus_rdata_o = st_q.tim[1];
            SEL_TIM2:  bus_rdata_o = st_q.tim[2];
            SEL_TIM3:  bus_rdata_o = st_q.tim[3];
            SEL_UBASE,
            SEL_UCUR:  bus_rdata_o = st_q.ubase;
            SEL_LBASE,
            SEL_LCUR:  bus_rdata_o = st_q.lbase;
            SEL_MASK:  bus_rdata_o = DATA_W'(st_q.mask);
            SEL_CTRL:  bus_rdata_o = st_q.ctrl;
            SEL_RAW:   bus_rdata_o = DATA_W'(st_q.raw);
            SEL_MSTAT: bus_rdata_o = DATA_W'(st_q.raw & st_q.mask);
            SEL_IDENT: bus_rdata_o = DATA_W'(id_byte);
            default:   bus_rdata_o = '0;
        endcase
    end

    assign cols_o     = st_q.cols;
    assign rows_o     = st_q.rows;
    assign depth_o    = st_q.ctrl[3:1];
    assign enabled_o  = st_q.ctrl[CTRL_EN_BIT] & st_q.ctrl[CTRL_PWR_BIT];
    assign wr_pulse_o = st_q.pulse;
endmodule

// File: rtl/lcdc_regfile_chk.sv
module lcdc_regfile_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [COL_W-1:0]  cols_o,
    input logic [ROW_W-1:0]  rows_o,
    input logic              wr_pulse_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int ID_LO  = (1 << WORD_W) - 8;

    logic [WORD_W-1:0] word;
    logic wr_any, wr_tim0, unmapped;
    logic [COL_W+1:0] exp_cols;

    assign word     = bus_addr_i[ADDR_W-1:2];
    assign wr_any   = bus_sel_i && bus_wr_i;
    assign wr_tim0  = wr_any && (int'(word) == 0);
    assign unmapped = (int'(word) > 12) && (int'(word) < ID_LO);
    assign exp_cols = (COL_W+2)'(((bus_wdata_i & 32'hFC) + 32'd4) * 32'd4);

    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse_o |-> $past(wr_any)); // R11

    AST_COLS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tim0 |=> $stable(cols_o)); // R3

    AST_COLS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tim0 |=> (COL_W+2)'(cols_o) == $past(exp_cols)); // R3

    AST_ROWS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rows_o) <= 1024); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> bus_rdata_o == '0); // R10
endmodule

bind lcdc_regfile lcdc_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cols_o      (cols_o),
    .rows_o      (rows_o),
    .wr_pulse_o  (wr_pulse_o)
);

// File: tb/tb_lcdc_regfile.sv
module tb_lcdc_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  layout = 2'd0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  irq_set = '0;
    logic [10:0] cols;
    logic [10:0] rows;
    logic [2:0]  depth;
    logic        enabled;
    logic        pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcdc_regfile dut (
        .clk(clk), .rst_n(rst_n), .layout_i(layout),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_set_i(irq_set),
        .cols_o(cols), .rows_o(rows), .depth_o(depth),
        .enabled_o(enabled), .wr_pulse_o(pulse)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; sel = 1'b1; wr = 1'b0;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1", "cols", 32'(cols), 0);
        chk("R1", "rows", 32'(rows), 0);
        chk("R1", "depth", 32'(depth), 0);
        chk("R1", "enabled", 32'(enabled), 0);
        chk("R1", "pulse", 32'(pulse), 0);
        bus_read(12'h000, d); chk("R1", "tim0", d, 0);
        bus_read(12'h01C, d); chk("R1", "ctrl", d, 0);
    endtask

    task automatic t_storage();
        logic [31:0] d;
        bus_write(12'h008, 32'hA5A5_0002); bus_write(12'h00C, 32'h1234_5678);
        bus_write(12'h010, 32'h8000_1000); bus_write(12'h014, 32'h8000_2000);
        bus_read(12'h008, d); chk("R2", "tim2", d, 32'hA5A5_0002);
        bus_read(12'h00C, d); chk("R2", "tim3", d, 32'h1234_5678);
        bus_read(12'h010, d); chk("R2", "ubase", d, 32'h8000_1000);
        bus_read(12'h014, d); chk("R2", "lbase", d, 32'h8000_2000);
        bus_read(12'h02C, d); chk("R2", "ucur", d, 32'h8000_1000);
        bus_read(12'h030, d); chk("R2", "lcur", d, 32'h8000_2000);
    endtask

    task automatic t_geometry();
        logic [31:0] d;
        bus_write(12'h000, 32'hFFFF_FF13);
        chk("R11", "pulse after write", 32'(pulse), 1);
        chk("R3", "cols 0x13", 32'(cols), 80);
        @(negedge clk);
        chk("R11", "pulse one cycle", 32'(pulse), 0);
        bus_read(12'h000, d); chk("R3", "tim0 readback", d, 32'hFFFF_FF13);
        bus_write(12'h000, 32'h0000_01FF);
        chk("R3", "cols max", 32'(cols), 1024);
        bus_write(12'h004, 32'hFFFF_F9DF);
        chk("R4", "rows 480", 32'(rows), 480);
        bus_write(12'h004, 32'h0000_07FF);
        chk("R4", "rows max", 32'(rows), 1024);
        chk("R3", "cols unchanged by tim1", 32'(cols), 1024);
    endtask

    task automatic t_control_base();
        layout = 2'd0;
        bus_write(12'h01C, 32'h0000_080D);
        chk("R5", "enabled both", 32'(enabled), 1);
        chk("R5", "depth 6", 32'(depth), 6);
        bus_write(12'h01C, 32'h0000_0001);
        chk("R5", "enable without power", 32'(enabled), 0);
        bus_write(12'h01C, 32'h0000_0802);
        chk("R5", "power without enable", 32'(enabled), 0);
        chk("R5", "depth 1", 32'(depth), 1);
    endtask

    task automatic t_swap();
        logic [31:0] d;
        do_reset();
        layout = 2'd1;
        bus_write(12'h018, 32'h0000_0801);
        chk("R6", "layout1 word6 is ctrl", 32'(enabled), 1);
        bus_write(12'h01C, 32'h0000_0013);
        chk("R6", "layout1 word7 no ctrl effect", 32'(enabled), 1);
        bus_read(12'h01C, d); chk("R6", "layout1 word7 mask", d, 32'h13);
        bus_read(12'h018, d); chk("R6", "layout1 word6 ctrl", d, 32'h801);
        layout = 2'd0;
        bus_read(12'h018, d); chk("R6", "base word6 mask", d, 32'h13);
        bus_read(12'h01C, d); chk("R6", "base word7 ctrl", d, 32'h801);
        layout = 2'd2;
        bus_write(12'h018, 32'h0000_0000);
        chk("R6", "layout2 word6 ctrl", 32'(enabled), 0);
        layout = 2'd0;
    endtask

    task automatic t_irq();
        logic [31:0] d;
        do_reset();
        layout = 2'd0;
        bus_write(12'h018, 32'hFFFF_FF0F);
        @(negedge clk); irq_set = 5'h15;
        @(negedge clk); irq_set = 5'h00;
        bus_read(12'h020, d); chk("R7", "raw", d, 32'h15);
        bus_read(12'h024, d); chk("R7", "masked", d, 32'h05);
        bus_write(12'h028, 32'hFFFF_FFE4);
        bus_read(12'h020, d); chk("R8", "raw after clear", d, 32'h11);
        // same-cycle set and clear of bit 0
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 12'h028; wdata = 32'h1; irq_set = 5'h01;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; irq_set = 5'h00;
        bus_read(12'h020, d); chk("R8", "set wins over clear", d, 32'h11);
        bus_write(12'h028, 32'h10);
        bus_read(12'h020, d); chk("R8", "clear bit4", d, 32'h01);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        logic [7:0] base_b [8];
        logic [7:0] ext_b [8];
        base_b = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        ext_b  = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int lay = 0; lay < 4; lay++) begin
            layout = 2'(lay);
            for (int i = 0; i < 8; i++) begin
                bus_read(12'hFE0 + 12'(i * 4), d);
                chk("R9", $sformatf("id layout%0d byte%0d", lay, i), d,
                    32'(lay >= 2 ? ext_b[i] : base_b[i]));
            end
        end
        layout = 2'd0;
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        do_reset();
        bus_write(12'h010, 32'hCAFE_0000);
        @(negedge clk);
        bus_write(12'h100, 32'hFFFF_FFFF);
        chk("R10", "no pulse unmapped write", 32'(pulse), 0);
        bus_write(12'h02C, 32'h1111_1111);
        chk("R10", "no pulse read-only write", 32'(pulse), 0);
        bus_write(12'hFE0, 32'h2222_2222);
        chk("R10", "no pulse id write", 32'(pulse), 0);
        bus_read(12'h010, d); chk("R10", "ubase untouched", d, 32'hCAFE_0000);
        bus_read(12'h100, d); chk("R10", "unmapped read", d, 0);
        bus_read(12'h034, d); chk("R10", "word13 read", d, 0);
        bus_read(12'hFDC, d); chk("R10", "below id read", d, 0);
        chk("R10", "cols untouched", 32'(cols), 0);
    endtask

    initial begin
        t_reset();
        t_storage();
        t_geometry();
        t_control_base();
        t_swap();
        t_irq();
        t_ident();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule